// File: doc/BRIEF.md
# Block-Copy DMA Engine

This block is a single-channel copy engine. Software loads a start address for the read side, a start address for the write side and an item count into registers, picks the item width and the address stepping in a control word, then raises a request bit. The engine then moves the block one item at a time. For each item it reads from the source over a simple memory master port, waits for the acknowledge, and writes the same data to the destination. Completion and failure each leave a sticky flag in the control word. Software polls these flags, or takes an interrupt when that is enabled.

A burst option makes each counted unit four items, so the count then gives the number of bursts. In burst mode both base addresses must sit on a 16-byte boundary. A start that breaks this rule is refused: the error flag is raised and the bus is never touched. Clearing the enable bit while a copy is running stops it once the item in flight is done, and the completion flag is not raised.

Top module: `memcpy_dma`

## Requirements
- R1: After reset all four registers read as zero, `mem_req` is low and `irq` is low.
- R2: Register offsets are 0x0 control, 0x4 source base, 0x8 destination base and 0xC count. Base and count registers read back what was written. In the control word, bit 0 is enable, bits 3:2 are mode, bit 4 is destination-decrement, bit 5 is source-decrement, bit 7 is fixed-source, bit 8 is interrupt enable, bit 9 is burst, bits 13:12 are width, bit 15 is demand, bit 16 is request, bit 18 is done and bit 20 is error. Every other bit reads zero.
- R3: Writing 1 to bit 16 sets a pending request. The copy starts on the first cycle in which the request and enable are both set. The request bit then reads zero. While enable is clear, a pending request causes no memory access.
- R4: Each item is read from the current source address and written unchanged to the current destination address. Width code 00, 01 or 10 gives 1, 2 or 4 bytes, and `mem_size` carries that code. Data sits in the low bytes of the 32-bit bus. After each item an address moves by the item size: up when its direction bit is 0, down when it is 1. Fixed-source keeps the source address constant.
- R5: The number of items moved equals the count, or four times the count in burst mode. A count of zero completes at once with no memory access.
- R6: Completion sets the done bit, which stays set until software writes 1 to bit 18. The error bit stays set until software writes 1 to bit 20.
- R7: A start with burst set and either base not 16-byte aligned, or with width code 11, sets the error bit and makes no memory access.
- R8: An acknowledge that comes with `mem_err` sets the error bit and ends the copy without setting done. A write that fails does not reach memory.
- R9: Clearing enable during a copy stops it after the item in flight. Done is not set.
- R10: `irq` is high exactly when interrupt enable is set and done or error is set.
- R11: Once `mem_req` is raised it stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Item width code |
| mem_wdata | output | 32 | Write data, low-justified |
| mem_rdata | input | 32 | Read data, low-justified |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access failed (valid with `mem_ack`) |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default 32-bit address and a 16-bit count, backed by a 256-byte memory. Source and destination regions are chosen so that copies in both directions stay disjoint. This small memory makes it cheap to sweep every width, both direction bits, fixed-source, burst and counts 0 to 3. The whole memory is compared against an arithmetic model after each run, which catches stray writes anywhere. Random acknowledge stalls on alternate runs exercise the request-hold rule. Directed runs cover misalignment, an injected write fault, an abort and a request held pending while enable is clear.

// File: rtl/memcpy_dma_pkg.sv
package memcpy_dma_pkg;
    localparam int unsigned REG_W = 32;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_SRC  = 4'h4;
    localparam logic [3:0] OFS_DST  = 4'h8;
    localparam logic [3:0] OFS_CNT  = 4'hC;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        logic       ddec;
        logic       sdec;
        logic       sfix;
        logic       sien;
        logic       burst;
        logic [1:0] width;
        logic       demand;
    } dma_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } dma_st_e;
endpackage

// File: rtl/memcpy_dma_regs.sv
module memcpy_dma_regs
    import memcpy_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output dma_cfg_t         cfg_o,
    output logic             sreq_o,
    output logic [AW-1:0]    src_o,
    output logic [AW-1:0]    dst_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_o,
    output logic             err_o,
    input  logic             start_i,
    input  logic             set_tc_i,
    input  logic             set_err_i
);
    typedef struct packed {
        dma_cfg_t         cfg;
        logic             sreq;
        logic             tc;
        logic             err;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            unique case (reg_addr)
                OFS_CTRL: begin
                    r_d.cfg.en     = reg_wdata[0];
                    r_d.cfg.mode   = reg_wdata[3:2];
                    r_d.cfg.ddec   = reg_wdata[4];
                    r_d.cfg.sdec   = reg_wdata[5];
                    r_d.cfg.sfix   = reg_wdata[7];
                    r_d.cfg.sien   = reg_wdata[8];
                    r_d.cfg.burst  = reg_wdata[9];
                    r_d.cfg.width  = reg_wdata[13:12];
                    r_d.cfg.demand = reg_wdata[15];
                    if (reg_wdata[16]) r_d.sreq = 1'b1;
                    if (reg_wdata[18]) r_d.tc   = 1'b0;
                    if (reg_wdata[20]) r_d.err  = 1'b0;
                end
                OFS_SRC: r_d.src = reg_wdata[AW-1:0];
                OFS_DST: r_d.dst = reg_wdata[AW-1:0];
                OFS_CNT: r_d.cnt = reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (start_i)   r_d.sreq = 1'b0;
        if (set_tc_i)  r_d.tc   = 1'b1;
        if (set_err_i) r_d.err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {11'b0, r_q.err, 1'b0, r_q.tc, 1'b0, r_q.sreq,
                                   r_q.cfg.demand, 1'b0, r_q.cfg.width, 2'b0,
                                   r_q.cfg.burst, r_q.cfg.sien, r_q.cfg.sfix, 1'b0,
                                   r_q.cfg.sdec, r_q.cfg.ddec, r_q.cfg.mode, 1'b0,
                                   r_q.cfg.en};
            OFS_SRC:  reg_rdata[AW-1:0]    = r_q.src;
            OFS_DST:  reg_rdata[AW-1:0]    = r_q.dst;
            OFS_CNT:  reg_rdata[CNT_W-1:0] = r_q.cnt;
            default:  reg_rdata = '0;
        endcase
    end

    assign cfg_o  = r_q.cfg;
    assign sreq_o = r_q.sreq;
    assign src_o  = r_q.src;
    assign dst_o  = r_q.dst;
    assign cnt_o  = r_q.cnt;
    assign tc_o   = r_q.tc;
    assign err_o  = r_q.err;
endmodule

// File: rtl/memcpy_dma_xfer.sv
module memcpy_dma_xfer
    import memcpy_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sreq_i,
    input  logic             burst_i,
    input  logic [1:0]       width_i,
    input  logic             sdec_i,
    input  logic             ddec_i,
    input  logic             sfix_i,
    input  logic [AW-1:0]    src_i,
    input  logic [AW-1:0]    dst_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             start_o,
    output logic             set_tc_o,
    output logic             set_err_o,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [REG_W-1:0] mem_wdata,
    input  logic [REG_W-1:0] mem_rdata,
    input  logic             mem_ack,
    input  logic             mem_err
);
    localparam int unsigned LEFT_W = CNT_W + 2;

    typedef struct packed {
        dma_st_e           st;
        logic [AW-1:0]     sa;
        logic [AW-1:0]     da;
        logic [LEFT_W-1:0] left;
        logic [REG_W-1:0]  data;
        logic [1:0]        size;
        logic              sdec;
        logic              ddec;
        logic              sfix;
    } xfer_t;

    xfer_t x_q, x_d;
    logic [AW-1:0] step;
    logic          bad_start;

    assign step      = AW'(4'd1 << x_q.size);
    assign bad_start = (width_i == 2'b11) ||
                       (burst_i && ((src_i[3:0] != 4'd0) || (dst_i[3:0] != 4'd0)));

    always_comb begin
        x_d       = x_q;
        start_o   = 1'b0;
        set_tc_o  = 1'b0;
        set_err_o = 1'b0;
        unique case (x_q.st)
            ST_IDLE: begin
                if (en_i && sreq_i) begin
                    start_o = 1'b1;
                    if (bad_start) begin
                        set_err_o = 1'b1;
                    end else if (cnt_i == '0) begin
                        set_tc_o = 1'b1;
                    end else begin
                        x_d.st   = ST_RD;
                        x_d.sa   = src_i;
                        x_d.da   = dst_i;
                        x_d.left = burst_i ? {cnt_i, 2'b00} : {2'b00, cnt_i};
                        x_d.size = width_i;
                        x_d.sdec = sdec_i;
                        x_d.ddec = ddec_i;
                        x_d.sfix = sfix_i;
                    end
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        set_err_o = 1'b1;
                        x_d.st    = ST_IDLE;
                    end else begin
                        x_d.data = mem_rdata;
                        x_d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        set_err_o = 1'b1;
                        x_d.st    = ST_IDLE;
                    end else begin
                        if (!x_q.sfix) x_d.sa = x_q.sdec ? x_q.sa - step : x_q.sa + step;
                        x_d.da   = x_q.ddec ? x_q.da - step : x_q.da + step;
                        x_d.left = x_q.left - 1'b1;
                        if (x_q.left == LEFT_W'(1)) begin
                            set_tc_o = 1'b1;
                            x_d.st   = ST_IDLE;
                        end else if (!en_i) begin
                            x_d.st = ST_IDLE;
                        end else begin
                            x_d.st = ST_RD;
                        end
                    end
                end
            end
            default: x_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign mem_req   = (x_q.st != ST_IDLE);
    assign mem_we    = (x_q.st == ST_WR);
    assign mem_addr  = (x_q.st == ST_WR) ? x_q.da : x_q.sa;
    assign mem_size  = x_q.size;
    assign mem_wdata = x_q.data;
endmodule

// File: rtl/memcpy_dma.sv
module memcpy_dma
    import memcpy_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);
    dma_cfg_t         cfg;
    logic             sreq, tc, err;
    logic             start, set_tc, set_err;
    logic [AW-1:0]    src, dst;
    logic [CNT_W-1:0] cnt;

    memcpy_dma_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg),
        .sreq_o    (sreq),
        .src_o     (src),
        .dst_o     (dst),
        .cnt_o     (cnt),
        .tc_o      (tc),
        .err_o     (err),
        .start_i   (start),
        .set_tc_i  (set_tc),
        .set_err_i (set_err)
    );

    memcpy_dma_xfer #(.AW(AW), .CNT_W(CNT_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (cfg.en),
        .sreq_i    (sreq),
        .burst_i   (cfg.burst),
        .width_i   (cfg.width),
        .sdec_i    (cfg.sdec),
        .ddec_i    (cfg.ddec),
        .sfix_i    (cfg.sfix),
        .src_i     (src),
        .dst_i     (dst),
        .cnt_i     (cnt),
        .start_o   (start),
        .set_tc_o  (set_tc),
        .set_err_o (set_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err)
    );

    assign irq = cfg.sien & (tc | err);
endmodule

// File: rtl/memcpy_dma_chk.sv
module memcpy_dma_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          mem_err,
    input logic          irq,
    input logic          sien,
    input logic          burst,
    input logic [AW-1:0] src,
    input logic [AW-1:0] dst,
    input logic          start,
    input logic          err
);
    // R11: an unacknowledged request is held unchanged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R7: misaligned burst start raises error and never reaches the bus
    assert_misalign_noaccess_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && burst && ((src[3:0] != 4'd0) || (dst[3:0] != 4'd0))) |=> (!mem_req && err));

    // R8: the error flag only rises from a refused start or a failed access
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(start) || $past(mem_req && mem_ack && mem_err)));

    // R10: no interrupt while it is disabled
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sien |-> !irq);
endmodule

bind memcpy_dma memcpy_dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .irq       (irq),
    .sien      (cfg.sien),
    .burst     (cfg.burst),
    .src       (src),
    .dst       (dst),
    .start     (start),
    .err       (err)
);

// File: tb/sim_memcpy_dma.sv
`timescale 1ns/1ps
module sim_memcpy_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack, mem_err;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] mem [256];
    logic [7:0] expm [256];
    bit         stall = 0, stall_en = 0;
    logic [7:0] lfsr = 8'h5A;
    bit         fault_en = 0;
    logic [7:0] fault_addr = '0;
    int         req_cycles = 0;
    int         wr_count = 0;

    always #2.5 clk = ~clk;

    memcpy_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq(irq)
    );

    assign mem_ack = mem_req && !stall;
    assign mem_err = fault_en && mem_req && mem_we && (mem_addr[7:0] == fault_addr);

    always_comb begin
        mem_rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < (1 << mem_size)) mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + k)];
    end

    always @(posedge clk) begin
        if (mem_req) req_cycles <= req_cycles + 1;
        if (mem_req && mem_we && mem_ack && !mem_err) begin
            wr_count <= wr_count + 1;
            for (int k = 0; k < 4; k++)
                if (k < (1 << mem_size)) mem[8'(mem_addr[7:0] + k)] <= mem_wdata[8*k +: 8];
        end
    end

    always @(negedge clk) begin
        lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stall = stall_en && lfsr[0];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(output logic [31:0] ctl);
        for (int i = 0; i < 3000; i++) begin
            rd(4'h0, ctl);
            if (ctl[18] || ctl[20]) break;
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i * 37 + seed * 11 + 5);
            expm[i] = mem[i];
        end
    endtask

    task automatic clr_counts();
        @(negedge clk);
        req_cycles = 0; wr_count = 0;
    endtask

    function automatic bit mem_match();
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) return 0;
        return 1;
    endfunction

    task automatic run_copy(input int w, input bit sd, input bit dd, input bit fx,
                            input bit bm, input int cnt, input bit ie);
        logic [31:0] ctl;
        int sbase, dbase, items, wb, sa, da;
        sbase = sd ? 'h70 : 'h10;
        dbase = dd ? 'hF0 : 'h80;
        items = bm ? cnt * 4 : cnt;
        wb = 1 << w;
        fill(w * 7 + cnt + int'(sd) * 3);
        for (int i = 0; i < items; i++) begin
            sa = fx ? sbase : (sd ? sbase - i * wb : sbase + i * wb);
            da = dd ? dbase - i * wb : dbase + i * wb;
            for (int k = 0; k < wb; k++) expm[(da + k) & 255] = expm[(sa + k) & 255];
        end
        wr(4'h0, 32'h0014_0000);
        wr(4'h4, sbase);
        wr(4'h8, dbase);
        wr(4'hC, cnt);
        clr_counts();
        wr(4'h0, 32'h1 | (32'(dd) << 4) | (32'(sd) << 5) | (32'(fx) << 7) |
                 (32'(ie) << 8) | (32'(bm) << 9) | (32'(w) << 12) | (32'h1 << 16));
        wait_done(ctl);
        repeat (2) @(negedge clk);
        check(mem_match(), "R4 memory image after copy", 32'(w), 32'(cnt));
        check(wr_count == items, "R5 items written", wr_count, items);
        if (cnt == 0) check(req_cycles == 0, "R5 zero count no access", req_cycles, 0);
        check(ctl[18] && !ctl[20], "R6 done set error clear", ctl, 32'h0004_0000);
        check(irq == ie, "R10 irq after done", irq, ie);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check(mem_req == 1'b0 && irq == 1'b0, "R1 outputs idle in reset", {mem_req, irq}, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            check(v == 0, "R1 register reset value", v, 0);
        end

        // R2: readback and reserved bits
        wr(4'h4, 32'h1234_5670);
        wr(4'h8, 32'hCAFE_0010);
        wr(4'hC, 32'h0000_ABCD);
        rd(4'h4, v); check(v == 32'h1234_5670, "R2 source readback", v, 32'h1234_5670);
        rd(4'h8, v); check(v == 32'hCAFE_0010, "R2 dest readback", v, 32'hCAFE_0010);
        rd(4'hC, v); check(v == 32'h0000_ABCD, "R2 count readback", v, 32'h0000_ABCD);
        wr(4'h0, 32'hFFFE_FFFE);
        rd(4'h0, v); check(v == 32'h0000_B3BC, "R2 control fields", v, 32'h0000_B3BC);
        wr(4'h0, 32'h0);

        // R3: request pending while enable clear
        fill(99);
        wr(4'h4, 32'h10); wr(4'h8, 32'h80); wr(4'hC, 32'h1);
        clr_counts();
        wr(4'h0, 32'h0001_2000);
        repeat (10) @(negedge clk);
        check(req_cycles == 0, "R3 no access without enable", req_cycles, 0);
        rd(4'h0, v); check(v[16] == 1'b1, "R3 request pending", v, 32'h0001_2000);
        wr(4'h0, 32'h0000_2001);
        wait_done(v);
        check(v[16] == 1'b0 && v[18], "R3 request self-cleared and copy done", v, 32'h0004_2001);
        check(wr_count == 1, "R3 one item moved", wr_count, 1);

        // R6: write one clears done
        wr(4'h0, 32'h0004_2001);
        rd(4'h0, v); check(v[18] == 1'b0, "R6 done cleared by write one", v, 32'h2001);

        // Sweep: R4 R5 R6 R10 (R11 under stalls)
        for (int w = 0; w < 3; w++)
            for (int s = 0; s < 2; s++)
                for (int d = 0; d < 2; d++)
                    for (int f = 0; f < 2; f++)
                        for (int b = 0; b < 2; b++)
                            for (int c = 0; c < 4; c++) begin
                                stall_en = (c + b) % 2;
                                run_copy(w, s[0], d[0], f[0], b[0], c, c[0]);
                            end
        stall_en = 0;

        // R7: misaligned burst
        fill(3);
        wr(4'h0, 32'h0014_0000);
        wr(4'h4, 32'h14); wr(4'h8, 32'h80); wr(4'hC, 32'h1);
        clr_counts();
        wr(4'h0, 32'h0001_2201);
        wait_done(v);
        check(v[20] && !v[18], "R7 misaligned burst error", v, 32'h0010_2201);
        check(req_cycles == 0, "R7 misaligned burst no access", req_cycles, 0);
        check(mem_match(), "R7 memory untouched", 0, 0);

        // R7: width code 11
        wr(4'h0, 32'h0014_0000);
        wr(4'h4, 32'h10);
        clr_counts();
        wr(4'h0, 32'h0001_3001);
        wait_done(v);
        check(v[20] && req_cycles == 0, "R7 reserved width refused", v, 32'h0010_3001);

        // R8: fault on second write
        fill(4);
        for (int k = 0; k < 4; k++) expm[8'h80 + k] = expm[8'h10 + k];
        wr(4'h0, 32'h0014_0000);
        wr(4'h4, 32'h10); wr(4'h8, 32'h80); wr(4'hC, 32'h4);
        fault_en = 1; fault_addr = 8'h84;
        clr_counts();
        wr(4'h0, 32'h0001_2101);
        wait_done(v);
        repeat (3) @(negedge clk);
        fault_en = 0;
        check(v[20] && !v[18], "R8 fault sets error not done", v, 32'h0010_2101);
        check(wr_count == 1, "R8 copy stops at fault", wr_count, 1);
        check(mem_req == 1'b0, "R8 bus idle after fault", mem_req, 0);
        check(mem_match(), "R8 failed write not stored", 0, 0);
        check(irq == 1'b1, "R10 irq on error", irq, 1);
        wr(4'h0, 32'h0010_2101);
        rd(4'h0, v);
        check(v[20] == 1'b0 && irq == 1'b0, "R6 error cleared by write one", v, 32'h2101);

        // R9: abort by clearing enable
        fill(5);
        wr(4'h0, 32'h0014_0000);
        wr(4'h4, 32'h10); wr(4'h8, 32'h80); wr(4'hC, 32'h8);
        clr_counts();
        wr(4'h0, 32'h0001_2001);
        while (wr_count < 3) @(negedge clk);
        wr(4'h0, 32'h0000_2000);
        repeat (20) @(negedge clk);
        rd(4'h0, v);
        check(!v[18] && !v[20], "R9 abort leaves done clear", v, 32'h2000);
        check(wr_count >= 3 && wr_count < 8, "R9 abort stops early", wr_count, 4);
        check(mem_req == 1'b0, "R9 bus idle after abort", mem_req, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule